// File: doc/BRIEF.md
# Programmable Button Sequence Lock

A clocked controller for a four-button combination lock. A four-bit button vector and a mode bit come in. The block keeps a combination of four digits, each a four-bit button vector. It drives two complementary status outputs, locked and unlocked, and a one-hot indicator that shows which digit is being programmed.

Raising the mode bit while the controller rests starts programming. The user then presses one button per digit. For each press, the controller waits for a non-zero vector, stores it in a capture step, and waits for the buttons to go back to zero before it moves to the next digit. After the fourth digit the controller rests again, whatever the mode bit has done in the meantime.

With the mode bit low, presses are compared in order against the stored digits. Four correct presses open the lock. Any later press closes it again. The inputs are assumed to be clean levels that are already synchronous to the clock. Each press is expected to last many clock cycles.

Top module: `btn_lock`

## Requirements
- R1: While rst_ni is low, and on the first sample after rst_ni is released, locked_o=1, unlocked_o=0 and seq_o=4'b0000. Reset also clears the stored digits to zero, so no press can match them.
- R2: locked_o and unlocked_o are complementary on every cycle.
- R3: seq_o is one-hot only while programming, with bit k set for digit k+1 (bit 0 for the first digit). It moves to the next bit only after the press for the current digit has been released. In every other state seq_o is zero.
- R4: If mode_i is 1 while the controller rests, programming starts within two clock edges. Once started, programming runs to the end of the fourth digit even if mode_i drops to 0. The controller then returns to rest with seq_o zero.
- R5: One press, however long it is held, stores exactly one digit.
- R6: The value stored for a digit is the button vector sampled in that digit's capture cycle. The later entry must present that same vector to match.
- R7: In lock mode (mode_i=0), four presses that equal digits 1 to 4 in order, each separated by a release, raise unlocked_o. It rises on the clock edge that samples the fourth press and stays high after that press is released.
- R8: A press that does not match the expected digit restarts the entry. If that press equals digit 1, it counts as the first digit of a new attempt.
- R9: In lock mode, a press with more than one bit set never matches.
- R10: While the lock is open after the final release, any non-zero press sets locked_o on the next edge. After the release the controller rests again.
- R11: In lock mode, a single long press advances the comparison by one digit only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 4 | Button levels, one bit per button, all zeros means released |
| mode_i | input | 1 | 1 = program, 0 = lock entry |
| locked_o | output | 1 | Lock closed |
| unlocked_o | output | 1 | Lock open |
| seq_o | output | 4 | One-hot digit being programmed, zero otherwise |

## Verification
All outputs are decoded from the state register. Each result therefore appears right after the clock edge that samples the causing input. A press raises unlocked_o, or raises locked_o when relocking, one edge after it is applied. A release moves seq_o to the next digit one edge after the buttons go back to zero. The bench drives inputs on falling edges and reads outputs on later falling edges, after at least one or two rising edges have passed. This keeps every check half a cycle away from the edge that changes the result. Releases are followed by three idle cycles, which covers the two-edge path back through rest.

// File: rtl/btn_lock_pkg.sv
package btn_lock_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRG_WAIT,
    ST_PRG_CAPT,
    ST_PRG_REL,
    ST_ENT_WAIT,
    ST_ENT_REL,
    ST_OPEN_HOLD,
    ST_OPEN,
    ST_RELOCK_REL
  } state_e;
endpackage

// File: rtl/btn_lock_digit_store.sv
module btn_lock_digit_store #(
  parameter int NUM_BTN    = 4,
  parameter int NUM_DIGITS = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_DIGITS-1:0]             load_i,
  input  logic [NUM_BTN-1:0]                btn_i,
  output logic [NUM_DIGITS-1:0][NUM_BTN-1:0] digits_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        digits_o[g] <= '0;
      else if (load_i[g]) digits_o[g] <= btn_i;
    end
  end
endmodule

// File: rtl/btn_lock_match.sv
module btn_lock_match #(
  parameter int NUM_BTN    = 4,
  parameter int NUM_DIGITS = 4,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [NUM_BTN-1:0]                 btn_i,
  input  logic [NUM_DIGITS-1:0][NUM_BTN-1:0] digits_i,
  input  logic [IDX_W-1:0]                   idx_i,
  output logic                               any_o,
  output logic                               hit_o,
  output logic                               first_hit_o
);
  logic single;

  always_comb begin
    any_o       = |btn_i;
    single      = $onehot(btn_i);
    // multi-button presses never match
    hit_o       = single && (btn_i == digits_i[idx_i]);
    first_hit_o = single && (btn_i == digits_i[0]);
  end
endmodule

// File: rtl/btn_lock_ctrl.sv
module btn_lock_ctrl #(
  parameter int NUM_DIGITS = 4,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mode_i,
  input  logic                      any_i,
  input  logic                      hit_i,
  input  logic                      first_hit_i,
  output btn_lock_pkg::state_e      state_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [NUM_DIGITS-1:0]     load_o,
  output logic [NUM_DIGITS-1:0]     seq_o,
  output logic                      locked_o,
  output logic                      unlocked_o
);
  import btn_lock_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_DIGITS - 1);
  localparam logic [IDX_W-1:0] AFTER_1ST = (NUM_DIGITS > 1) ? IDX_W'(1) : '0;

  state_e           st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_prog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        idx_d = '0;
        st_d  = mode_i ? ST_PRG_WAIT : ST_ENT_WAIT;
      end
      ST_PRG_WAIT: if (any_i) st_d = ST_PRG_CAPT;
      ST_PRG_CAPT: st_d = ST_PRG_REL;
      ST_PRG_REL: if (!any_i) begin
        if (idx_q == LAST_IDX) begin
          st_d  = ST_IDLE;
          idx_d = '0;
        end else begin
          st_d  = ST_PRG_WAIT;
          idx_d = idx_q + 1'b1;
        end
      end
      ST_ENT_WAIT: begin
        if (mode_i) begin
          st_d  = ST_IDLE;
          idx_d = '0;
        end else if (any_i) begin
          if (hit_i && idx_q == LAST_IDX) begin
            st_d  = ST_OPEN_HOLD;
            idx_d = '0;
          end else if (hit_i) begin
            st_d  = ST_ENT_REL;
            idx_d = idx_q + 1'b1;
          end else if (first_hit_i) begin
            st_d  = ST_ENT_REL;
            idx_d = AFTER_1ST;
          end else begin
            st_d  = ST_ENT_REL;
            idx_d = '0;
          end
        end
      end
      ST_ENT_REL:    if (!any_i) st_d = ST_ENT_WAIT;
      ST_OPEN_HOLD:  if (!any_i) st_d = ST_OPEN;
      ST_OPEN:       if (any_i)  st_d = ST_RELOCK_REL;
      ST_RELOCK_REL: if (!any_i) st_d = ST_IDLE;
      default: begin
        st_d  = ST_IDLE;
        idx_d = '0;
      end
    endcase
  end

  assign in_prog = (st_q == ST_PRG_WAIT) || (st_q == ST_PRG_CAPT) ||
                   (st_q == ST_PRG_REL);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    assign load_o[g] = (st_q == ST_PRG_CAPT) && (idx_q == IDX_W'(g));
    assign seq_o[g]  = in_prog && (idx_q == IDX_W'(g));
  end

  assign unlocked_o = (st_q == ST_OPEN_HOLD) || (st_q == ST_OPEN);
  assign locked_o   = !unlocked_o;
  assign state_o    = st_q;
  assign idx_o      = idx_q;
endmodule

// File: rtl/btn_lock.sv
module btn_lock #(
  parameter int NUM_BTN    = 4,
  parameter int NUM_DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_BTN-1:0]    btn_i,
  input  logic                  mode_i,
  output logic                  locked_o,
  output logic                  unlocked_o,
  output logic [NUM_DIGITS-1:0] seq_o
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  btn_lock_pkg::state_e               st;
  logic [IDX_W-1:0]                   idx;
  logic [NUM_DIGITS-1:0]              load;
  logic [NUM_DIGITS-1:0][NUM_BTN-1:0] digits;
  logic                               any, hit, first_hit;

  btn_lock_digit_store #(.NUM_BTN(NUM_BTN), .NUM_DIGITS(NUM_DIGITS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .btn_i    (btn_i),
    .digits_o (digits)
  );

  btn_lock_match #(.NUM_BTN(NUM_BTN), .NUM_DIGITS(NUM_DIGITS)) u_match (
    .btn_i       (btn_i),
    .digits_i    (digits),
    .idx_i       (idx),
    .any_o       (any),
    .hit_o       (hit),
    .first_hit_o (first_hit)
  );

  btn_lock_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .any_i       (any),
    .hit_i       (hit),
    .first_hit_i (first_hit),
    .state_o     (st),
    .idx_o       (idx),
    .load_o      (load),
    .seq_o       (seq_o),
    .locked_o    (locked_o),
    .unlocked_o  (unlocked_o)
  );
endmodule

// File: rtl/btn_lock_chk.sv
module btn_lock_chk #(
  parameter int NUM_BTN    = 4,
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_BTN-1:0]    btn_i,
  input logic                  locked_o,
  input logic                  unlocked_o,
  input logic [NUM_DIGITS-1:0] seq_o,
  input logic [NUM_DIGITS-1:0] load_i,
  input btn_lock_pkg::state_e  state_i
);
  import btn_lock_pkg::*;

  a_r2_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o != unlocked_o);

  a_r3_seq_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(seq_o));

  a_r3_seq_off_when_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |-> (seq_o == '0));

  a_r1_idle_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> (locked_o && seq_o == '0));

  a_r5_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|load_i) |=> !(|load_i));

  a_r6_load_after_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|load_i) |-> ($past(btn_i) != '0));

  a_r10_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OPEN && btn_i != '0) |=> locked_o);
endmodule

bind btn_lock btn_lock_chk #(.NUM_BTN(NUM_BTN), .NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .btn_i      (btn_i),
  .locked_o   (locked_o),
  .unlocked_o (unlocked_o),
  .seq_o      (seq_o),
  .load_i     (load),
  .state_i    (st)
);

// File: tb/btn_lock_tb_top.sv
module btn_lock_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btn = '0;
  logic       mode = 1'b0;
  logic       locked, unlocked;
  logic [3:0] seq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  btn_lock dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .btn_i      (btn),
    .mode_i     (mode),
    .locked_o   (locked),
    .unlocked_o (unlocked),
    .seq_o      (seq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input logic [3:0] b, input int cyc);
    @(negedge clk) btn = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic rel();
    btn = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] b);
    hold(b, 3);
    rel();
  endtask

  task automatic program4(input logic [3:0] d0, input logic [3:0] d1,
                          input logic [3:0] d2, input logic [3:0] d3, input int cyc);
    logic [3:0] d [4];
    d = '{d0, d1, d2, d3};
    @(negedge clk) mode = 1'b1;
    repeat (2) @(negedge clk);
    mode = 1'b0;  // R4: programming continues with mode low
    chk(8'(seq), 8'h01, "R4 start");
    for (int k = 0; k < 4; k++) begin
      hold(d[k], cyc);
      chk(8'(seq), 8'(1 << k), "R3 held");
      chk(8'(locked), 8'h01, "R2 prog");
      rel();
      chk(8'(seq), (k == 3) ? 8'h00 : 8'(1 << (k + 1)), "R5 advance");
    end
  endtask

  task automatic t_reset();
    chk(8'(locked), 8'h01, "R1 locked");
    chk(8'(unlocked), 8'h00, "R1 unlocked");
    chk(8'(seq), 8'h00, "R1 seq");
    @(negedge clk) rst_n = 1'b1;
    chk(8'(locked), 8'h01, "R1 after release");
    press(4'b0001);
    chk(8'(unlocked), 8'h00, "R1 cleared digits");
  endtask

  task automatic t_wrong_second();
    press(4'b1000);
    press(4'b0010);
    press(4'b0100);
    press(4'b0010);
    press(4'b0001);
    chk(8'(locked), 8'h01, "R8 wrong second");
    chk(8'(seq), 8'h00, "R3 entry seq");
  endtask

  task automatic t_unlock();
    press(4'b1000);
    press(4'b0100);
    press(4'b0010);
    hold(4'b0001, 1);
    chk(8'(unlocked), 8'h01, "R7 open at press");
    chk(8'(locked), 8'h00, "R2 open");
    rel();
    chk(8'(unlocked), 8'h01, "R7 open after release");
  endtask

  task automatic t_relock();
    hold(4'b0100, 1);
    chk(8'(locked), 8'h01, "R10 relock");
    rel();
    chk(8'(locked), 8'h01, "R10 after release");
  endtask

  task automatic t_restart_first();
    press(4'b1000);
    press(4'b1000);
    press(4'b0100);
    press(4'b0010);
    press(4'b0001);
    chk(8'(unlocked), 8'h01, "R8 first digit restarts");
  endtask

  task automatic t_multibit();
    press(4'b1000);
    press(4'b0110);
    press(4'b0100);
    press(4'b0010);
    press(4'b0001);
    chk(8'(locked), 8'h01, "R9 multi mid");
    press(4'b1100);
    press(4'b0100);
    press(4'b0010);
    press(4'b0001);
    chk(8'(locked), 8'h01, "R9 multi first");
  endtask

  task automatic t_long_hold();
    program4(4'b0001, 4'b0001, 4'b0001, 4'b0001, 25);
    hold(4'b0001, 40);
    chk(8'(locked), 8'h01, "R11 long hold");
    rel();
    press(4'b0001);
    press(4'b0001);
    chk(8'(locked), 8'h01, "R11 three presses");
    press(4'b0001);
    chk(8'(unlocked), 8'h01, "R6 repeated digits");
    t_relock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    program4(4'b1000, 4'b0100, 4'b0010, 4'b0001, 4);
    t_wrong_second();
    t_unlock();
    t_relock();
    t_restart_first();
    t_relock();
    t_multibit();
    t_long_hold();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule